// File: doc/BRIEF.md
# Priority Interrupt Controller

This block stands between up to eight interrupting peripherals and the single maskable interrupt input of a processor. Each peripheral line passes through a synchronizer. A rising edge on the line records a pending request. Software can block each request with a per-line mask bit. The controller keeps a set of in-service levels so that handlers can nest. It raises its interrupt output only when the most urgent unmasked request is more urgent than every level already being serviced. Line 0 is the most urgent and line 7 the least.

The processor answers the interrupt with a one-cycle acknowledge pulse. The controller then moves the winning request into service and presents a vector number equal to a base of 8 plus the line number. A handler signals completion by writing a fixed end-of-interrupt code over a small port bus. That write retires the most urgent level in service. The same bus writes and reads the mask, and it reads back the pending and in-service sets.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the mask reads 0xFF, the pending and in-service sets read 0x00, and `int_out` is low.
- R2: A rising edge on `irq_in[n]` sets pending bit n. The bit is visible on the port bus after the third rising clock edge that samples the new level. This happens even when bit n is masked. A line that stays high does not set the bit again.
- R3: A write to port 0x21 loads the mask from `io_wdata`. Reading port 0x21 returns the mask. A mask bit of 1 blocks line n and a 0 lets it through.
- R4: Reading port 0x20 returns the pending set when `rd_sel` is 0 and the in-service set when `rd_sel` is 1. Bit n of each set belongs to line n. Any other port address reads 0x00.
- R5: `int_out` is high exactly when some unmasked pending line exists and its lowest index is strictly lower than the lowest set in-service index, or when no in-service bit is set.
- R6: An `inta` cycle taken while `int_out` is high does three things: it clears the winning pending bit, sets its in-service bit, and loads `vec_out` with 8 plus the winning line number from the next cycle onward.
- R7: A more urgent line can interrupt while a less urgent one is in service, so several in-service bits are set at once.
- R8: Writing 0x20 to port 0x20 clears only the lowest-index set in-service bit. Any other data written to port 0x20 leaves the in-service set unchanged.
- R9: An end-of-interrupt write while the in-service set is empty changes nothing.
- R10: An `inta` cycle taken while `int_out` is low leaves the pending set, the in-service set and `vec_out` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 8 | Peripheral request lines, edge sensitive |
| int_out | output | 1 | Interrupt to the processor |
| inta | input | 1 | One-cycle acknowledge from the processor |
| vec_out | output | 8 | Vector of the last acknowledged line |
| io_wr | input | 1 | Port write strobe |
| io_addr | input | 8 | Port address |
| io_wdata | input | 8 | Port write data |
| rd_sel | input | 1 | Selects in-service (1) or pending (0) set on port 0x20 reads |
| io_rdata | output | 8 | Combinational port read data |

## Verification
Request lines take three clock edges to reach the pending set. This comes from two synchronizer flops and one edge register. `int_out` is combinational and follows the pending set on that same edge. Mask loads, acknowledges and end-of-interrupt writes show up in the registers and in `vec_out` one edge after the cycle that carries them. Port reads are combinational in the address and select. The reference model updates on each rising edge from the inputs held since the previous falling edge. All outputs are compared at the falling edge. Named checks on the pending set are placed exactly two and three edges after a line rises, which tests the three-edge latency.

// File: rtl/pic_pkg.sv
package pic_pkg;
   typedef enum logic [1:0] {
      IO_IDLE,
      IO_MASK_WR,
      IO_EOI,
      IO_OTHER
   } io_op_e;
endpackage

// File: rtl/pic_req_sync.sv
module pic_req_sync #(
   parameter int N      = 8,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] lines,
   output logic [N-1:0] rise
);
   logic [N-1:0] synced;
   logic [N-1:0] last_q;

   generate
      if (STAGES == 0) begin : g_direct
         assign synced = lines;
      end else begin : g_chain
         logic [N-1:0] stg_q [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int k = 0; k < STAGES; k++) stg_q[k] <= '0;
            end else begin
               stg_q[0] <= lines;
               for (int k = 1; k < STAGES; k++) stg_q[k] <= stg_q[k-1];
            end
         end
         assign synced = stg_q[STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) last_q <= '0;
      else        last_q <= synced;
   end

   assign rise = synced & ~last_q;
endmodule

// File: rtl/pic_prio_enc.sv
module pic_prio_enc #(
   parameter int N     = 8,
   localparam int IDX_W = $clog2(N)
) (
   input  logic [N-1:0]     req,
   output logic             valid,
   output logic [IDX_W-1:0] idx,
   output logic [N-1:0]     onehot
);
   always_comb begin
      valid = 1'b0;
      idx   = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) begin
            valid = 1'b1;
            idx   = IDX_W'(i);
         end
      end
      onehot = valid ? (N'(1) << idx) : '0;
   end
endmodule

// File: rtl/pic_io_decode.sv
module pic_io_decode
   import pic_pkg::*;
#(
   parameter int ADDR_W    = 8,
   parameter int DATA_W    = 8,
   parameter int EOI_PORT  = 'h20,
   parameter int MASK_PORT = 'h21,
   parameter int EOI_CODE  = 'h20
) (
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output io_op_e            op
);
   always_comb begin
      op = IO_IDLE;
      if (wr) begin
         if (addr == ADDR_W'(MASK_PORT))
            op = IO_MASK_WR;
         else if (addr == ADDR_W'(EOI_PORT) && wdata == DATA_W'(EOI_CODE))
            op = IO_EOI;
         else
            op = IO_OTHER;
      end
   end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
   import pic_pkg::*;
#(
   parameter int NUM_IRQ     = 8,
   parameter int DATA_W      = 8,
   parameter int ADDR_W      = 8,
   parameter int VEC_BASE    = 8,
   parameter int SYNC_STAGES = 2,
   parameter int EOI_PORT    = 'h20,
   parameter int MASK_PORT   = 'h21,
   parameter int EOI_CODE    = 'h20
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_IRQ-1:0] irq_in,
   output logic               int_out,
   input  logic               inta,
   output logic [DATA_W-1:0]  vec_out,
   input  logic               io_wr,
   input  logic [ADDR_W-1:0]  io_addr,
   input  logic [DATA_W-1:0]  io_wdata,
   input  logic               rd_sel,
   output logic [DATA_W-1:0]  io_rdata
);
   localparam int IDX_W = $clog2(NUM_IRQ);

   generate
      if (NUM_IRQ < 2 || NUM_IRQ > DATA_W) begin : g_bad_width
         $error("NUM_IRQ must lie between 2 and DATA_W");
      end
      if (VEC_BASE + NUM_IRQ > (1 << DATA_W)) begin : g_bad_vec
         $error("vector range exceeds DATA_W");
      end
      if (SYNC_STAGES < 0) begin : g_bad_sync
         $error("SYNC_STAGES must not be negative");
      end
   endgenerate

   logic [NUM_IRQ-1:0] irr_q, isr_q, imr_q;
   logic [NUM_IRQ-1:0] rise;
   logic               pend_v, svc_v;
   logic [IDX_W-1:0]   pend_idx, svc_idx;
   logic [NUM_IRQ-1:0] pend_oh, svc_oh;
   logic               ack, eoi, mask_wr;
   io_op_e             op;

   pic_req_sync #(.N(NUM_IRQ), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .lines (irq_in),
      .rise  (rise)
   );

   pic_prio_enc #(.N(NUM_IRQ)) u_pend_enc (
      .req    (irr_q & ~imr_q),
      .valid  (pend_v),
      .idx    (pend_idx),
      .onehot (pend_oh)
   );

   pic_prio_enc #(.N(NUM_IRQ)) u_svc_enc (
      .req    (isr_q),
      .valid  (svc_v),
      .idx    (svc_idx),
      .onehot (svc_oh)
   );

   pic_io_decode #(
      .ADDR_W    (ADDR_W),
      .DATA_W    (DATA_W),
      .EOI_PORT  (EOI_PORT),
      .MASK_PORT (MASK_PORT),
      .EOI_CODE  (EOI_CODE)
   ) u_dec (
      .wr    (io_wr),
      .addr  (io_addr),
      .wdata (io_wdata),
      .op    (op)
   );

   assign mask_wr = (op == IO_MASK_WR);
   assign eoi     = (op == IO_EOI);
   assign int_out = pend_v && (!svc_v || (pend_idx < svc_idx));
   assign ack     = inta && int_out;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irr_q   <= '0;
         isr_q   <= '0;
         imr_q   <= '1;
         vec_out <= '0;
      end else begin
         irr_q <= (irr_q & ~(ack ? pend_oh : '0)) | rise;
         isr_q <= (isr_q & ~(eoi ? svc_oh : '0)) | (ack ? pend_oh : '0);
         if (mask_wr) imr_q <= io_wdata[NUM_IRQ-1:0];
         if (ack) vec_out <= DATA_W'(VEC_BASE) + DATA_W'(pend_idx);
      end
   end

   always_comb begin
      io_rdata = '0;
      if (io_addr == ADDR_W'(MASK_PORT))
         io_rdata = DATA_W'(imr_q);
      else if (io_addr == ADDR_W'(EOI_PORT))
         io_rdata = rd_sel ? DATA_W'(isr_q) : DATA_W'(irr_q);
   end
endmodule

// File: rtl/pic_checker.sv
module pic_checker #(
   parameter int N        = 8,
   parameter int DATA_W   = 8,
   parameter int VEC_BASE = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              int_out,
   input logic              inta,
   input logic [DATA_W-1:0] vec_out,
   input logic [N-1:0]      irr,
   input logic [N-1:0]      isr,
   input logic [N-1:0]      imr,
   input logic              mask_wr,
   input logic              eoi,
   input logic [DATA_W-1:0] wdata
);
   assert_int_needs_pending_R5: assert property (@(posedge clk) disable iff (!rst_n)
      int_out |-> (|(irr & ~imr)));

   assert_no_preempt_top_R5: assert property (@(posedge clk) disable iff (!rst_n)
      isr[0] |-> !int_out);

   assert_ack_vector_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (inta && int_out) |=> (int'(vec_out) >= VEC_BASE && int'(vec_out) < VEC_BASE + N));

   assert_ack_adds_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (inta && int_out && !eoi) |=> ($countones(isr) == $past($countones(isr)) + 1));

   assert_eoi_when_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi && isr == '0 && !(inta && int_out)) |=> (isr == '0));

   assert_mask_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
      mask_wr |=> (imr == $past(wdata[N-1:0])));

   assert_idle_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (inta && !int_out && !eoi) |=> (isr == $past(isr) && $stable(vec_out)));
endmodule

bind prio_irq_ctrl pic_checker #(
   .N        (NUM_IRQ),
   .DATA_W   (DATA_W),
   .VEC_BASE (VEC_BASE)
) u_pic_checker (
   .clk     (clk),
   .rst_n   (rst_n),
   .int_out (int_out),
   .inta    (inta),
   .vec_out (vec_out),
   .irr     (irr_q),
   .isr     (isr_q),
   .imr     (imr_q),
   .mask_wr (mask_wr),
   .eoi     (eoi),
   .wdata   (io_wdata)
);

// File: tb/prio_irq_ctrl_test.sv
module prio_irq_ctrl_test;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] irq_in = '0;
   logic       int_out;
   logic       inta = 1'b0;
   logic [7:0] vec_out;
   logic       io_wr = 1'b0;
   logic [7:0] io_addr = '0;
   logic [7:0] io_wdata = '0;
   logic       rd_sel = 1'b0;
   logic [7:0] io_rdata;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   // reference model state
   int m_irr [8], m_isr [8], m_imr [8];
   int m_h1 [8], m_h2 [8], m_h3 [8];
   int m_vec;

   prio_irq_ctrl uut (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .int_out(int_out),
      .inta(inta), .vec_out(vec_out), .io_wr(io_wr), .io_addr(io_addr),
      .io_wdata(io_wdata), .rd_sel(rd_sel), .io_rdata(io_rdata)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic int best_pend();
      for (int i = 0; i < 8; i++) if (m_irr[i] != 0 && m_imr[i] == 0) return i;
      return -1;
   endfunction

   function automatic int best_svc();
      for (int i = 0; i < 8; i++) if (m_isr[i] != 0) return i;
      return 8;
   endfunction

   function automatic int exp_int();
      int p = best_pend();
      return (p >= 0 && p < best_svc()) ? 1 : 0;
   endfunction

   function automatic int pack(input int a [8]);
      int v = 0;
      for (int i = 0; i < 8; i++) if (a[i] != 0) v += (1 << i);
      return v;
   endfunction

   function automatic int exp_rd();
      if (io_addr == 8'h21) return pack(m_imr);
      if (io_addr == 8'h20) return rd_sel ? pack(m_isr) : pack(m_irr);
      return 0;
   endfunction

   task automatic model_update();
      if (!rst_n) begin
         for (int i = 0; i < 8; i++) begin
            m_irr[i] = 0; m_isr[i] = 0; m_imr[i] = 1;
            m_h1[i] = 0; m_h2[i] = 0; m_h3[i] = 0;
         end
         m_vec = 0;
      end else begin
         int w = best_pend();
         int s = best_svc();
         bit ack = (inta == 1'b1) && (exp_int() != 0);
         bit eoi = io_wr && io_addr == 8'h20 && io_wdata == 8'h20;
         if (eoi && s < 8) m_isr[s] = 0;
         if (ack) begin
            m_irr[w] = 0;
            m_isr[w] = 1;
            m_vec = 8 + w;
         end
         for (int i = 0; i < 8; i++) begin
            if (m_h2[i] != 0 && m_h3[i] == 0) m_irr[i] = 1;
            m_h3[i] = m_h2[i];
            m_h2[i] = m_h1[i];
            m_h1[i] = int'(irq_in[i]);
         end
         if (io_wr && io_addr == 8'h21)
            for (int i = 0; i < 8; i++) m_imr[i] = int'(io_wdata[i]);
      end
   endtask

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) begin
         @(posedge clk);
         model_update();
         @(negedge clk);
         chk("R5 int_out vs model", int'(int_out), exp_int());
         chk("R6 vec_out vs model", int'(vec_out), m_vec);
         chk("R4 io_rdata vs model", int'(io_rdata), exp_rd());
      end
   endtask

   task automatic rd(input logic [7:0] a, input logic s, input string req, input int exp);
      io_addr = a;
      rd_sel = s;
      #1;
      chk(req, int'(io_rdata), exp);
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      io_wr = 1'b1; io_addr = a; io_wdata = d;
      step(1);
      io_wr = 1'b0;
   endtask

   task automatic pulse_ack();
      inta = 1'b1;
      step(1);
      inta = 1'b0;
   endtask

   initial begin
      step(3);
      @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      rd(8'h21, 1'b0, "R1 mask after reset", 'hFF);
      rd(8'h20, 1'b0, "R1 pending after reset", 'h00);
      rd(8'h20, 1'b1, "R1 in-service after reset", 'h00);
      chk("R1 int_out after reset", int'(int_out), 0);
      // R2: latency and latch while masked
      irq_in = 8'h08;
      step(2);
      rd(8'h20, 1'b0, "R2 pending two edges after rise", 'h00);
      step(1);
      rd(8'h20, 1'b0, "R2 pending three edges after rise", 'h08);
      chk("R5 masked request gives no int", int'(int_out), 0);
      irq_in = 8'h00;
      // R3: mask write and readback
      wr(8'h21, 8'h00);
      rd(8'h21, 1'b0, "R3 mask readback", 'h00);
      chk("R5 unmasked request raises int", int'(int_out), 1);
      irq_in = 8'h20;
      step(3);
      rd(8'h20, 1'b0, "R2 second line latched", 'h28);
      // R6: acknowledge line 3
      pulse_ack();
      chk("R6 vector for line 3", int'(vec_out), 'h0B);
      rd(8'h20, 1'b1, "R6 in-service after ack", 'h08);
      rd(8'h20, 1'b0, "R6 pending after ack", 'h20);
      chk("R5 lower line cannot preempt", int'(int_out), 0);
      // R7: nesting with line 1
      irq_in = 8'h22;
      step(3);
      chk("R7 higher line raises int", int'(int_out), 1);
      pulse_ack();
      chk("R7 vector for line 1", int'(vec_out), 'h09);
      rd(8'h20, 1'b1, "R7 two levels in service", 'h0A);
      // R10: acknowledge while idle
      pulse_ack();
      chk("R10 vector unchanged", int'(vec_out), 'h09);
      rd(8'h20, 1'b1, "R10 in-service unchanged", 'h0A);
      rd(8'h20, 1'b0, "R10 pending unchanged", 'h20);
      // R8: end of interrupt
      wr(8'h20, 8'h60);
      rd(8'h20, 1'b1, "R8 other data ignored", 'h0A);
      wr(8'h20, 8'h20);
      rd(8'h20, 1'b1, "R8 top level retired", 'h08);
      chk("R8 int stays low", int'(int_out), 0);
      wr(8'h20, 8'h20);
      rd(8'h20, 1'b1, "R8 last level retired", 'h00);
      chk("R8 pending line now raises int", int'(int_out), 1);
      pulse_ack();
      chk("R6 vector for line 5", int'(vec_out), 'h0D);
      step(5);
      rd(8'h20, 1'b0, "R2 held level no retrigger", 'h00);
      wr(8'h20, 8'h20);
      // R9: EOI on empty set
      wr(8'h20, 8'h20);
      rd(8'h20, 1'b1, "R9 empty eoi in-service", 'h00);
      rd(8'h20, 1'b0, "R9 empty eoi pending", 'h00);
      chk("R9 empty eoi int", int'(int_out), 0);
      rd(8'h22, 1'b0, "R4 unused port reads zero", 'h00);
      // mask blocks one line
      irq_in = 8'h00;
      step(3);
      wr(8'h21, 8'h02);
      irq_in = 8'h02;
      step(3);
      rd(8'h20, 1'b0, "R2 masked line latched", 'h02);
      chk("R3 masked line no int", int'(int_out), 0);
      wr(8'h21, 8'h00);
      chk("R3 unmask raises int", int'(int_out), 1);
      pulse_ack();
      chk("R6 vector after unmask", int'(vec_out), 'h09);
      step(2);
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         failures++;
         $display("FAIL watchdog all requirements actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule